// File: doc/BRIEF.md
# Send-Ring Queue Control Registers

This block holds the software-visible state of one send channel's descriptor ring in host memory. Software programs the ring base address and a control word through a simple word-addressed write/read port. The control word carries the ring size, the producer index, an enable, a stop-on-link-error option, and two command bits: one zeroes the indices and one aborts the pending transaction.

The block tracks the consumer index and advances it each time the fetch engine reports that it has consumed a descriptor. From the two indices and the control state it drives a fetch request, a paused flag, a one-cycle abort pulse, the ring base address and the index of the next descriptor to fetch. When the stop-on-link-error option is set, a link error latches a stop that holds the queue paused until software clears it.

A control write with the top bit set is a preserve write. It changes only the producer index, so software can post new descriptors without rewriting the rest of the control word.

Top module: `txq_regs`

## Requirements
- R1: The base register (word address BASE_OFS, default 0) stores write-data bits 31:4. Bits 3:0 read as zero and writes to them are ignored. `ring_base` shows the stored address with its low four bits zero.
- R2: The control word (word address CTL_OFS, default 1) reads producer index in bits 4:0, consumer index in 12:8, ring length minus one in 20:16, enable in 24, stop-on-link-error in 28, paused in 29 and entries-available in 30. Every other bit reads 0, including bits 25, 26 and 31. Any other address reads 0.
- R3: Each `consume` pulse while entries are available increments the consumer index modulo (length field + 1). A `consume` pulse while the ring is empty is ignored.
- R4: Entries-available is 1 exactly when the producer and consumer indices differ. `fetch_req` is 1 only when enable is set, no link-error stop is latched, and entries are available.
- R5: Clearing enable with a full write sets paused and drops `fetch_req`, and both indices keep their values. Setting enable again resumes fetching.
- R6: A full control write with bit 25 set zeroes both indices, and this takes priority over the producer field in the same write. Writing 0 to bit 25 has no effect on the indices.
- R7: A full control write with bit 26 set drives `abort_pulse` high for exactly the one cycle after the write. Writing 0 to bit 26 produces no pulse.
- R8: While stop-on-link-error is set, `link_err` latches a stop: paused becomes 1 and `fetch_req` becomes 0. While the option is clear, `link_err` has no effect.
- R9: A latched link-error stop clears on a full control write that sets enable or sets bit 25.
- R10: A control write with bit 31 set (preserve write) updates only the producer index. Length, enable, stop option, reset and abort bits in the same write are ignored.
- R11: A written producer index is masked to the ring length, so that it is the written value AND the length field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| consume | input | 1 | Fetch engine consumed one descriptor |
| link_err | input | 1 | Link error indication |
| fetch_req | output | 1 | Descriptors are pending and fetching is allowed |
| fetch_idx | output | 5 | Consumer index (next descriptor to fetch) |
| ring_base | output | 32 | Ring base address |
| paused | output | 1 | Queue is disabled or stopped by a link error |
| abort_pulse | output | 1 | One-cycle abort command |

## Verification
Register writes, consume pulses and link errors are captured at one rising edge. Read data, `fetch_req`, `paused` and `fetch_idx` are combinational from that state, so they are due right after that edge. `abort_pulse` also rises at that edge and falls at the next one. The bench changes inputs on falling edges and holds each for one full cycle. It samples at the falling edge that follows the capturing edge. For the abort it samples once more one cycle later to confirm the pulse has ended. Reads set the address on a falling edge and sample a moment later.

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int AW = 4,
  parameter logic [AW-1:0] BASE_OFS = 0,
  parameter logic [AW-1:0] CTL_OFS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          consume,
  input  logic          link_err,
  output logic          fetch_req,
  output logic [4:0]    fetch_idx,
  output logic [31:0]   ring_base,
  output logic          paused,
  output logic          abort_pulse
);
  logic [31:4] base_q;
  logic [4:0]  prod_q, cons_q, qlen_q;
  logic        en_q, stop_en_q, err_stop_q, abort_q;

  wire base_wr = reg_wr && (reg_addr == BASE_OFS);
  wire ctl_wr  = reg_wr && (reg_addr == CTL_OFS);
  wire full_wr = ctl_wr && !reg_wdata[31];
  wire q_reset = full_wr && reg_wdata[25];
  wire [4:0] len_nx = full_wr ? reg_wdata[20:16] : qlen_q;
  wire avail = prod_q != cons_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      prod_q     <= '0;
      cons_q     <= '0;
      qlen_q     <= '0;
      en_q       <= 1'b0;
      stop_en_q  <= 1'b0;
      err_stop_q <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      if (base_wr) base_q <= reg_wdata[31:4];
      abort_q <= full_wr && reg_wdata[26];
      if (full_wr) begin
        qlen_q    <= reg_wdata[20:16];
        en_q      <= reg_wdata[24];
        stop_en_q <= reg_wdata[28];
      end
      if (q_reset) begin
        prod_q <= '0;
        cons_q <= '0;
      end else begin
        if (ctl_wr) prod_q <= reg_wdata[4:0] & len_nx;
        if (full_wr) cons_q <= cons_q & len_nx;
        else if (consume && avail) cons_q <= (cons_q + 5'd1) & qlen_q;
      end
      if (link_err && stop_en_q) err_stop_q <= 1'b1;
      else if (q_reset || (full_wr && reg_wdata[24])) err_stop_q <= 1'b0;
    end
  end

  assign paused      = !en_q || err_stop_q;
  assign fetch_req   = en_q && !err_stop_q && avail;
  assign fetch_idx   = cons_q;
  assign ring_base   = {base_q, 4'b0000};
  assign abort_pulse = abort_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == BASE_OFS) reg_rdata = ring_base;
    else if (reg_addr == CTL_OFS) begin
      reg_rdata[4:0]   = prod_q;
      reg_rdata[12:8]  = cons_q;
      reg_rdata[20:16] = qlen_q;
      reg_rdata[24]    = en_q;
      reg_rdata[28]    = stop_en_q;
      reg_rdata[29]    = paused;
      reg_rdata[30]    = avail;
    end
  end
endmodule

// File: rtl/txq_regs_chk.sv
module txq_regs_chk #(
  parameter int AW = 4,
  parameter logic [AW-1:0] BASE_OFS = 0,
  parameter logic [AW-1:0] CTL_OFS = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          consume,
  input logic          link_err,
  input logic          fetch_req,
  input logic          paused,
  input logic          abort_pulse,
  input logic [4:0]    prod_q,
  input logic [4:0]    cons_q,
  input logic [4:0]    qlen_q,
  input logic          en_q,
  input logic          stop_en_q
);
  wire ctl_w = reg_wr && reg_addr == CTL_OFS;

  assert_base_low_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == BASE_OFS |-> reg_rdata[3:0] == 4'h0);

  assert_cons_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !consume && !ctl_w |=> $stable(cons_q));

  assert_fetch_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !paused && prod_q != cons_q);

  assert_reset_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && !reg_wdata[31] && reg_wdata[25] |=> prod_q == 5'd0 && cons_q == 5'd0);

  assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> $past(ctl_w && !reg_wdata[31] && reg_wdata[26]));

  assert_link_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_err && stop_en_q |=> paused && !fetch_req);

  assert_preserve_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_w && reg_wdata[31] |=> $stable(qlen_q) && $stable(en_q) && $stable(stop_en_q));
endmodule

bind txq_regs txq_regs_chk #(.AW(AW), .BASE_OFS(BASE_OFS), .CTL_OFS(CTL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .consume(consume),
  .link_err(link_err), .fetch_req(fetch_req), .paused(paused),
  .abort_pulse(abort_pulse), .prod_q(prod_q), .cons_q(cons_q),
  .qlen_q(qlen_q), .en_q(en_q), .stop_en_q(stop_en_q)
);

// File: tb/sim_txq_regs.sv
module sim_txq_regs;
  logic clk = 0, rst_n = 0, reg_wr = 0, consume = 0, link_err = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata, ring_base;
  logic [4:0]  fetch_idx;
  logic fetch_req, paused, abort_pulse;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  txq_regs u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .consume(consume),
    .link_err(link_err), .fetch_req(fetch_req), .fetch_idx(fetch_idx),
    .ring_base(ring_base), .paused(paused), .abort_pulse(abort_pulse));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse_consume(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); consume = 1;
      @(negedge clk); consume = 0;
    end
  endtask

  task automatic pulse_link;
    @(negedge clk); link_err = 1;
    @(negedge clk); link_err = 0;
  endtask

  task automatic t_reset_state;
    logic [31:0] d;
    rd(1, d); chk("R2 reset ctl", d, 32'h2000_0000);
    rd(0, d); chk("R1 reset base", d, 0);
    chk("R4 reset fetch_req", fetch_req, 0);
    rd(5, d); chk("R2 unmapped addr", d, 0);
  endtask

  task automatic t_base;
    logic [31:0] d;
    wr(0, 32'hDEAD_BEEF);
    rd(0, d); chk("R1 base read", d, 32'hDEAD_BEE0);
    chk("R1 ring_base", ring_base, 32'hDEAD_BEE0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(1, 32'h19E7_E0E3);
    rd(1, d); chk("R2 layout and reserved", d, 32'h5107_0003);
    chk("R4 fetch_req", fetch_req, 1);
    chk("R3 fetch_idx", fetch_idx, 0);
  endtask

  task automatic t_consume;
    logic [31:0] d;
    pulse_consume(3);
    rd(1, d); chk("R3 consume to empty", d, 32'h1107_0303);
    chk("R4 empty fetch_req", fetch_req, 0);
    pulse_consume(1);
    chk("R3 empty consume ignored", fetch_idx, 3);
  endtask

  task automatic t_preserve_wrap;
    logic [31:0] d;
    wr(1, 32'h8000_0001);
    rd(1, d); chk("R10 preserve prod", d, 32'h5107_0301);
    pulse_consume(5);
    chk("R3 wrap", fetch_idx, 0);
    pulse_consume(1);
    chk("R3 after wrap", fetch_idx, 1);
    chk("R4 caught up", fetch_req, 0);
    wr(1, 32'h8000_001F);
    rd(1, d); chk("R11 prod masked", d[4:0], 7);
    wr(1, 32'h8700_0002);
    rd(1, d); chk("R10 preserve ignores others", d, 32'h5107_0102);
    chk("R10 no abort", abort_pulse, 0);
  endtask

  task automatic t_pause;
    logic [31:0] d;
    wr(1, 32'h1007_0002);
    rd(1, d); chk("R5 paused keeps indices", d, 32'h7007_0102);
    chk("R5 fetch_req off", fetch_req, 0);
    wr(1, 32'h1107_0002);
    chk("R5 resume", fetch_req, 1);
    chk("R6 zero in bit 25 keeps cons", fetch_idx, 1);
  endtask

  task automatic t_abort;
    logic [31:0] d;
    wr(1, 32'h1507_0002);
    chk("R7 abort high", abort_pulse, 1);
    @(negedge clk); chk("R7 abort one cycle", abort_pulse, 0);
    rd(1, d); chk("R7 abort bit reads 0", d, 32'h5107_0102);
  endtask

  task automatic t_link;
    logic [31:0] d;
    pulse_link;
    chk("R8 stop paused", paused, 1);
    chk("R8 stop fetch_req", fetch_req, 0);
    rd(1, d); chk("R8 status bit", d[29], 1);
    wr(1, 32'h1107_0002);
    chk("R9 enable clears stop", paused, 0);
    wr(1, 32'h0107_0002);
    pulse_link;
    chk("R8 option clear ignored", paused, 0);
    chk("R8 option clear fetch_req", fetch_req, 1);
  endtask

  task automatic t_reset_cmd;
    logic [31:0] d;
    wr(1, 32'h1107_0002);
    pulse_link;
    chk("R8 stopped again", paused, 1);
    wr(1, 32'h1307_0005);
    rd(1, d); chk("R6 reset zeroes indices", d, 32'h1107_0000);
    chk("R9 stop cleared", paused, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_state;
    t_base;
    t_layout;
    t_consume;
    t_preserve_wrap;
    t_pause;
    t_abort;
    t_link;
    t_reset_cmd;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule